// File: doc/BRIEF.md
# Interrupt Vector Dispatch Unit

This block turns an incoming interrupt or exception request into the information a core needs to enter the handler. A request carries an 8-bit vector, a source tag (external device, internal exception or software-raised), the current privilege level of the running code, and, for page faults, the faulting address. The unit reads the descriptor for that vector from a local descriptor memory. The memory address is the sum of a programmable base register and the vector number. The unit then returns the handler entry address, the code selector, the gate kind, whether the interrupt-enable flag must be cleared, and the kernel stack pointer and stack selector held in a configuration register pair.

Software-raised requests are checked against the privilege level stored in the descriptor. When the check fails, the request is sent on to the protection-fault vector 13, and the descriptor of vector 13 is read in its place. When the descriptor that is finally used is marked absent, the unit reports a descriptor fault instead of a handler. When vector 14 is dispatched, the address that came with the request is kept in a fault-address register.

Requests use a valid/ready handshake. The unit handles one request at a time and holds its result until the consumer acknowledges it. Descriptors, the base register and the stack register pair are written through simple write ports while the unit is idle.

Top module: `vec_dispatch`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and fault_addr is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready then stays 0 until the result is acknowledged. rsp_valid rises one clock edge after the accepting edge, or two edges after it when the request is redirected (R5).
- R3: The descriptor for vector V is read at memory address (base + V) modulo the memory depth of 512 entries. A descriptor word has the handler offset in bits [31:0], the code selector in [47:32], the descriptor privilege level in [49:48], the present flag in bit 50 and the gate kind in bit 51 (1 = trap, 0 = interrupt).
- R4: On a successful dispatch, rsp_vec is the dispatched vector, rsp_entry is the descriptor offset, rsp_sel is its selector and rsp_gate_trap is its gate bit. rsp_np_fault is 0.
- R5: For source code 2 (software-raised), the request passes only when req_cpl is numerically less than or equal to the descriptor privilege level. A refused request is dispatched as vector 13 using the descriptor at base + 13, whatever the present flag of the original descriptor. Source codes 0 (external), 1 (exception) and 3 (treated as external) skip the check.
- R6: When the descriptor finally used has present = 0, rsp_np_fault is 1. rsp_vec carries that vector, and rsp_entry, rsp_sel, rsp_gate_trap, rsp_clr_ie, rsp_ksp and rsp_kss are all 0.
- R7: rsp_clr_ie is 1 exactly when a present interrupt gate (bit 51 = 0) is dispatched. A trap gate gives 0.
- R8: On a successful dispatch, rsp_ksp and rsp_kss equal the values last written through the stack configuration port.
- R9: fault_addr takes the request's req_faddr when vector 14 is dispatched successfully. It is left unchanged by every other outcome, including a refused or absent vector 14.
- R10: While rsp_valid is 1 and rsp_ack is 0, all result outputs hold their values. After the edge on which rsp_ack is sampled, rsp_valid is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base_we | input | 1 | Write strobe for the table base register |
| cfg_base | input | 9 | New table base address |
| cfg_stk_we | input | 1 | Write strobe for the kernel stack register pair |
| cfg_ksp | input | 32 | New kernel stack pointer |
| cfg_kss | input | 16 | New kernel stack selector |
| tbl_we | input | 1 | Descriptor memory write strobe |
| tbl_waddr | input | 9 | Descriptor memory write address |
| tbl_wdata | input | 52 | Descriptor word (layout in R3) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_vec | input | 8 | Requested vector |
| req_src | input | 2 | Source: 0 external, 1 exception, 2 software, 3 external |
| req_cpl | input | 2 | Current privilege level of the requester |
| req_faddr | input | 32 | Faulting address sent with the request |
| rsp_valid | output | 1 | Result available |
| rsp_ack | input | 1 | Consumer takes the result |
| rsp_vec | output | 8 | Vector actually dispatched or faulted |
| rsp_np_fault | output | 1 | Descriptor absent fault |
| rsp_entry | output | 32 | Handler entry address |
| rsp_sel | output | 16 | Handler code selector |
| rsp_gate_trap | output | 1 | 1 for trap gate, 0 for interrupt gate |
| rsp_clr_ie | output | 1 | Clear the interrupt-enable flag |
| rsp_ksp | output | 32 | Kernel stack pointer for the handler |
| rsp_kss | output | 16 | Kernel stack selector for the handler |
| fault_addr | output | 32 | Last page-fault address |

## Verification
The hardest outcome to reach is a refused software request whose redirect to vector 13 then lands on an absent descriptor. This takes two table reads in a row and must end in a descriptor fault for vector 13, not for the original vector. The bench fills the table with a computed pattern in which every address that is 5 modulo 7 is absent. It then moves the base register to 6, so that base + 13 falls on an absent entry, and raises a software vector whose privilege level is below the requester's. A second hard case is address wraparound: the base is set near the top of the memory, so that base plus vector overflows the table.

// File: rtl/vd_pkg.sv
package vd_pkg;
    localparam int VEC_W  = 8;
    localparam int OFS_W  = 32;
    localparam int SEL_W  = 16;
    localparam int DPL_W  = 2;
    localparam int SRC_W  = 2;
    localparam int DESC_W = OFS_W + SEL_W + DPL_W + 2;

    localparam logic [VEC_W-1:0] VEC_GP = VEC_W'(13);
    localparam logic [VEC_W-1:0] VEC_PF = VEC_W'(14);

    localparam logic [SRC_W-1:0] SRC_EXT = 2'd0;
    localparam logic [SRC_W-1:0] SRC_EXC = 2'd1;
    localparam logic [SRC_W-1:0] SRC_SW  = 2'd2;

    typedef struct packed {
        logic             trap;
        logic             present;
        logic [DPL_W-1:0] dpl;
        logic [SEL_W-1:0] sel;
        logic [OFS_W-1:0] ofs;
    } desc_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOOK    = 2'd1,
        ST_LOOK_GP = 2'd2,
        ST_HOLD    = 2'd3
    } st_e;
endpackage

// File: rtl/vd_desc_ram.sv
module vd_desc_ram #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 52
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        if (rd_en) begin
            rdata_q <= mem_q[rd_addr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/vd_cfg_regs.sv
module vd_cfg_regs #(
    parameter int ADDR_W = 9,
    parameter int SP_W   = 32,
    parameter int SS_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              stk_we,
    input  logic [SP_W-1:0]   ksp_wdata,
    input  logic [SS_W-1:0]   kss_wdata,
    output logic [ADDR_W-1:0] base,
    output logic [SP_W-1:0]   ksp,
    output logic [SS_W-1:0]   kss
);
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [SP_W-1:0]   ksp;
        logic [SS_W-1:0]   kss;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (base_we) begin
            cfg_d.base = base_wdata;
        end
        if (stk_we) begin
            cfg_d.ksp = ksp_wdata;
            cfg_d.kss = kss_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign base = cfg_q.base;
    assign ksp  = cfg_q.ksp;
    assign kss  = cfg_q.kss;
endmodule

// File: rtl/vd_access_check.sv
module vd_access_check
    import vd_pkg::*;
(
    input  desc_t             desc,
    input  logic [SRC_W-1:0]  src,
    input  logic [DPL_W-1:0]  cpl,
    output logic              refuse,
    output logic              present
);
    logic needs_check;

    always_comb begin
        needs_check = (src == SRC_SW);
        refuse      = needs_check && (cpl > desc.dpl);
        present     = desc.present;
    end
endmodule

// File: rtl/vec_dispatch.sv
module vec_dispatch
    import vd_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int SP_W   = 32,
    parameter int FA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_base_we,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              cfg_stk_we,
    input  logic [SP_W-1:0]   cfg_ksp,
    input  logic [SEL_W-1:0]  cfg_kss,
    input  logic              tbl_we,
    input  logic [ADDR_W-1:0] tbl_waddr,
    input  logic [DESC_W-1:0] tbl_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VEC_W-1:0]  req_vec,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [DPL_W-1:0]  req_cpl,
    input  logic [FA_W-1:0]   req_faddr,
    output logic              rsp_valid,
    input  logic              rsp_ack,
    output logic [VEC_W-1:0]  rsp_vec,
    output logic              rsp_np_fault,
    output logic [OFS_W-1:0]  rsp_entry,
    output logic [SEL_W-1:0]  rsp_sel,
    output logic              rsp_gate_trap,
    output logic              rsp_clr_ie,
    output logic [SP_W-1:0]   rsp_ksp,
    output logic [SEL_W-1:0]  rsp_kss,
    output logic [FA_W-1:0]   fault_addr
);
    typedef struct packed {
        st_e              st;
        logic [VEC_W-1:0] vec;
        logic [SRC_W-1:0] src;
        logic [DPL_W-1:0] cpl;
        logic [FA_W-1:0]  faddr;
        logic [VEC_W-1:0] rvec;
        logic             np;
        logic [OFS_W-1:0] entry;
        logic [SEL_W-1:0] sel;
        logic             trap;
        logic             clr_ie;
        logic [SP_W-1:0]  ksp;
        logic [SEL_W-1:0] kss;
        logic [FA_W-1:0]  fault_addr;
    } state_t;

    state_t q, d;

    logic [ADDR_W-1:0] base;
    logic [SP_W-1:0]   ksp;
    logic [SEL_W-1:0]  kss;

    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [VEC_W-1:0]  look_vec;
    logic [DESC_W-1:0] rdata;
    desc_t             rdesc;
    logic              refuse;
    logic              present;
    logic              do_fin;
    logic [VEC_W-1:0]  fin_vec;

    vd_cfg_regs #(
        .ADDR_W (ADDR_W),
        .SP_W   (SP_W),
        .SS_W   (SEL_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_we    (cfg_base_we),
        .base_wdata (cfg_base),
        .stk_we     (cfg_stk_we),
        .ksp_wdata  (cfg_ksp),
        .kss_wdata  (cfg_kss),
        .base       (base),
        .ksp        (ksp),
        .kss        (kss)
    );

    vd_desc_ram #(
        .ADDR_W (ADDR_W),
        .DATA_W (DESC_W)
    ) u_ram (
        .clk     (clk),
        .we      (tbl_we),
        .waddr   (tbl_waddr),
        .wdata   (tbl_wdata),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rdata   (rdata)
    );

    assign rdesc = rdata;

    vd_access_check u_chk_acc (
        .desc    (rdesc),
        .src     (q.src),
        .cpl     (q.cpl),
        .refuse  (refuse),
        .present (present)
    );

    always_comb begin
        d        = q;
        rd_en    = 1'b0;
        do_fin   = 1'b0;
        fin_vec  = q.vec;
        look_vec = (q.st == ST_LOOK) ? VEC_GP : req_vec;
        rd_addr  = base + ADDR_W'(look_vec);

        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    rd_en   = 1'b1;
                    d.st    = ST_LOOK;
                    d.vec   = req_vec;
                    d.src   = req_src;
                    d.cpl   = req_cpl;
                    d.faddr = req_faddr;
                end
            end
            ST_LOOK: begin
                if (refuse) begin
                    rd_en = 1'b1;
                    d.st  = ST_LOOK_GP;
                end else begin
                    do_fin  = 1'b1;
                    fin_vec = q.vec;
                end
            end
            ST_LOOK_GP: begin
                do_fin  = 1'b1;
                fin_vec = VEC_GP;
            end
            ST_HOLD: begin
                if (rsp_ack) begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (do_fin) begin
            d.st   = ST_HOLD;
            d.rvec = fin_vec;
            d.np   = !present;
            if (present) begin
                d.entry  = rdesc.ofs;
                d.sel    = rdesc.sel;
                d.trap   = rdesc.trap;
                d.clr_ie = !rdesc.trap;
                d.ksp    = ksp;
                d.kss    = kss;
                if (fin_vec == VEC_PF) begin
                    d.fault_addr = q.faddr;
                end
            end else begin
                d.entry  = '0;
                d.sel    = '0;
                d.trap   = 1'b0;
                d.clr_ie = 1'b0;
                d.ksp    = '0;
                d.kss    = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready     = (q.st == ST_IDLE);
    assign rsp_valid     = (q.st == ST_HOLD);
    assign rsp_vec       = q.rvec;
    assign rsp_np_fault  = q.np;
    assign rsp_entry     = q.entry;
    assign rsp_sel       = q.sel;
    assign rsp_gate_trap = q.trap;
    assign rsp_clr_ie    = q.clr_ie;
    assign rsp_ksp       = q.ksp;
    assign rsp_kss       = q.kss;
    assign fault_addr    = q.fault_addr;
endmodule

// File: rtl/vd_checker.sv
module vd_checker
    import vd_pkg::*;
#(
    parameter int SP_W = 32,
    parameter int FA_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_ack,
    input logic [VEC_W-1:0] rsp_vec,
    input logic             rsp_np_fault,
    input logic [OFS_W-1:0] rsp_entry,
    input logic [SEL_W-1:0] rsp_sel,
    input logic             rsp_gate_trap,
    input logic             rsp_clr_ie,
    input logic [SP_W-1:0]  rsp_ksp,
    input logic [FA_W-1:0]  fault_addr
);
    assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready && !rsp_valid);

    assert_ready_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid));

    assert_np_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_np_fault |-> rsp_entry == '0 && rsp_sel == '0 && !rsp_clr_ie
                                      && !rsp_gate_trap && rsp_ksp == '0);

    assert_gate_ie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_np_fault |-> rsp_clr_ie != rsp_gate_trap);

    assert_fa_only_pf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_addr) |-> rsp_valid && rsp_vec == VEC_PF && !rsp_np_fault);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ack |=> rsp_valid && $stable(rsp_vec) && $stable(rsp_entry)
                                  && $stable(rsp_np_fault) && $stable(rsp_sel)
                                  && $stable(rsp_ksp) && $stable(rsp_clr_ie));

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ack |=> req_ready && !rsp_valid);
endmodule

bind vec_dispatch vd_checker #(
    .SP_W (SP_W),
    .FA_W (FA_W)
) u_vd_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_ack       (rsp_ack),
    .rsp_vec       (rsp_vec),
    .rsp_np_fault  (rsp_np_fault),
    .rsp_entry     (rsp_entry),
    .rsp_sel       (rsp_sel),
    .rsp_gate_trap (rsp_gate_trap),
    .rsp_clr_ie    (rsp_clr_ie),
    .rsp_ksp       (rsp_ksp),
    .fault_addr    (fault_addr)
);

// File: tb/sim_vec_dispatch.sv
module sim_vec_dispatch;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 9;
    localparam int DEPTH      = 1 << ADDR_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_base_we = 1'b0;
    logic [8:0]  cfg_base = '0;
    logic        cfg_stk_we = 1'b0;
    logic [31:0] cfg_ksp = '0;
    logic [15:0] cfg_kss = '0;
    logic        tbl_we = 1'b0;
    logic [8:0]  tbl_waddr = '0;
    logic [51:0] tbl_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_vec = '0;
    logic [1:0]  req_src = '0;
    logic [1:0]  req_cpl = '0;
    logic [31:0] req_faddr = '0;
    logic        rsp_valid;
    logic        rsp_ack = 1'b0;
    logic [7:0]  rsp_vec;
    logic        rsp_np_fault;
    logic [31:0] rsp_entry;
    logic [15:0] rsp_sel;
    logic        rsp_gate_trap;
    logic        rsp_clr_ie;
    logic [31:0] rsp_ksp;
    logic [15:0] rsp_kss;
    logic [31:0] fault_addr;

    vec_dispatch u0 (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0]  vec;
        logic        np;
        logic [31:0] entry;
        logic [15:0] sel;
        logic        trap;
        logic        clr;
        logic [31:0] ksp;
        logic [15:0] kss;
        logic [31:0] fa;
        int          at;
        string       tag;
    } exp_t;

    exp_t sb[$];

    logic [51:0] shadow [DEPTH];
    int          base_m = 0;
    logic [31:0] ksp_m = '0;
    logic [15:0] kss_m = '0;
    logic [31:0] fa_m = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R3 layout: trap[51] present[50] dpl[49:48] sel[47:32] ofs[31:0]
    function automatic logic [51:0] mkdesc(input int a);
        logic [31:0] ofs;
        logic [15:0] sel;
        ofs = 32'h1000_0000 + 32'(a * 16);
        sel = 16'h0008 + 16'(a);
        return {a[0], (a % 7) != 5, 2'(a % 4), sel, ofs};
    endfunction

    task automatic wr_tbl(input int a, input logic [51:0] w);
        @(negedge clk);
        tbl_we = 1'b1; tbl_waddr = 9'(a); tbl_wdata = w;
        shadow[a] = w;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic quiesce();
        while (sb.size() != 0 || !req_ready) @(negedge clk);
    endtask

    task automatic set_base(input int b);
        quiesce();
        cfg_base_we = 1'b1; cfg_base = 9'(b);
        base_m = b;
        @(negedge clk);
        cfg_base_we = 1'b0;
    endtask

    task automatic set_stack(input logic [31:0] sp, input logic [15:0] ss);
        quiesce();
        cfg_stk_we = 1'b1; cfg_ksp = sp; cfg_kss = ss;
        ksp_m = sp; kss_m = ss;
        @(negedge clk);
        cfg_stk_we = 1'b0;
    endtask

    task automatic send(input logic [7:0] v, input logic [1:0] src, input logic [1:0] cpl,
                        input logic [31:0] fad, input string tag);
        exp_t        e;
        logic [51:0] dw;
        int          lat;
        logic [7:0]  fv;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_vec = v; req_src = src; req_cpl = cpl; req_faddr = fad;
        dw  = shadow[(base_m + int'(v)) % DEPTH];
        lat = 1;
        fv  = v;
        if (src == 2'd2 && cpl > dw[49:48]) begin
            fv  = 8'd13;
            dw  = shadow[(base_m + 13) % DEPTH];
            lat = 2;
        end
        e.vec = fv;
        e.tag = tag;
        if (!dw[50]) begin
            e.np = 1'b1; e.entry = '0; e.sel = '0; e.trap = 1'b0; e.clr = 1'b0;
            e.ksp = '0; e.kss = '0;
        end else begin
            e.np = 1'b0; e.entry = dw[31:0]; e.sel = dw[47:32]; e.trap = dw[51];
            e.clr = !dw[51]; e.ksp = ksp_m; e.kss = kss_m;
            if (fv == 8'd14) fa_m = fad;
        end
        e.fa = fa_m;
        e.at = cyc + 1 + lat;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: pops expected items and compares as results appear
    int held = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                exp_t e;
                if (sb.size() == 0) begin
                    chk(1'b0, "R2", "unexpected result", 64'(rsp_vec), 64'hFFFF);
                end else begin
                    e = sb.pop_front();
                    chk(cyc == e.at, "R2", {e.tag, " latency"}, 64'(cyc), 64'(e.at));
                    chk(rsp_vec == e.vec, e.tag, "rsp_vec", 64'(rsp_vec), 64'(e.vec));
                    chk(rsp_np_fault == e.np, e.tag, "np_fault", 64'(rsp_np_fault), 64'(e.np));
                    chk(rsp_entry == e.entry && rsp_sel == e.sel, e.tag, "entry/sel",
                        {rsp_sel, rsp_entry}, {e.sel, e.entry});
                    chk(rsp_gate_trap == e.trap && rsp_clr_ie == e.clr, e.tag, "R7 gate/clr",
                        {rsp_gate_trap, rsp_clr_ie}, {e.trap, e.clr});
                    chk(rsp_ksp == e.ksp && rsp_kss == e.kss, e.tag, "R8 stack",
                        {rsp_kss, rsp_ksp}, {e.kss, e.ksp});
                    chk(fault_addr == e.fa, e.tag, "R9 fault_addr", 64'(fault_addr), 64'(e.fa));
                    for (int k = 0; k < held % 3; k++) begin
                        @(negedge clk);
                        chk(rsp_valid && rsp_vec == e.vec && rsp_entry == e.entry
                            && rsp_np_fault == e.np, "R10", "hold",
                            {rsp_valid, rsp_vec, rsp_entry}, {1'b1, e.vec, e.entry});
                    end
                    held++;
                    rsp_ack = 1'b1;
                    @(negedge clk);
                    rsp_ack = 1'b0;
                    chk(req_ready && !rsp_valid, "R10", "release",
                        {req_ready, rsp_valid}, 64'b10);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R2 actual %0d expected %0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk(fault_addr == '0, "R1", "fault_addr", 64'(fault_addr), 64'd0);

        for (int a = 0; a < DEPTH; a++) wr_tbl(a, mkdesc(a));
        set_base(0);
        set_stack(32'hC000_1000, 16'h0010);

        send(8'd32, 2'd0, 2'd3, 32'h0, "R4");           // external, skips check
        send(8'd3, 2'd1, 2'd3, 32'h0, "R4");            // exception, trap gate
        send(8'd14, 2'd1, 2'd0, 32'hDEAD_0040, "R9");   // page fault latched
        send(8'd5, 2'd0, 2'd0, 32'h0, "R6");            // absent descriptor
        send(8'd7, 2'd2, 2'd3, 32'h0, "R5");            // sw, dpl 3 allows cpl 3
        send(8'd14, 2'd2, 2'd3, 32'hBAD0_0000, "R5");   // sw refused -> 13, fa kept
        send(8'd12, 2'd2, 2'd1, 32'h0, "R5");           // refused before absent check
        send(8'd14, 2'd2, 2'd0, 32'h1234_5678, "R9");   // sw page fault allowed
        send(8'd11, 2'd3, 2'd3, 32'h0, "R5");           // code 3 skips check
        send(8'd255, 2'd0, 2'd0, 32'h0, "R3");
        send(8'd0, 2'd1, 2'd0, 32'h0, "R3");

        set_stack(32'hC000_8000, 16'h0018);
        send(8'd40, 2'd0, 2'd0, 32'h0, "R8");

        set_base(6);
        send(8'd1, 2'd2, 2'd3, 32'h0, "R5");            // addr 7, dpl 3 ok
        send(8'd4, 2'd2, 2'd3, 32'h0, "R6");            // refused, 13 absent at 19
        send(8'd14, 2'd0, 2'd0, 32'hFACE_0000, "R9");   // addr 20 present

        set_base(500);
        send(8'd20, 2'd0, 2'd0, 32'h0, "R3");           // wraps to address 8
        send(8'd19, 2'd1, 2'd0, 32'h0, "R6");           // wraps to address 7

        quiesce();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule